// File: doc/BRIEF.md
# Serial Converter Read Controller

This block is the host-side master for a two-channel, 8-bit successive-approximation converter reached over a three-wire serial link. The link has an active-low select, a serial clock, and separate data lines in each direction. A one-cycle start request, together with a 2-bit input-configuration code, launches one transaction. The controller pulls select low and sends a start bit and two configuration bits. It then clocks the result back twice: most significant bit first, then least significant bit first. Both copies share the LSB.

The two received copies are compared. When they agree, the value is committed to the result output. When they differ, the previous result is kept and a mismatch flag is raised. A one-cycle done pulse marks the end of every transaction.

The serial clock is produced from the system clock. Each of its half-periods lasts a parameterised number of system cycles, so the integrator can meet the converter's frequency window and its setup and hold times.

Top module: `sadc_reader`

## Requirements
- R1: After reset, select is high, the serial clock is low, done and mismatch are 0, and the result is 0.
- R2: A start request seen while idle pulls select low in the next cycle with the data line at 1. That 1 is the start bit, sampled by the converter on the first rising serial clock edge.
- R3: The configuration code is captured when start is accepted. Its bit 1 (1 = single-ended, 0 = differential) is sent on the 2nd rising edge, and its bit 0 (odd/sign) on the 3rd. The four codes select: 10 = channel 0 single-ended, 11 = channel 1 single-ended, 00 = channel 0 positive against channel 1, 01 = channel 1 positive against channel 0.
- R4: From the 4th rising edge to the end of the transaction, the data line is held at 1.
- R5: Each serial clock half-period lasts HALF_DIV system cycles, starting with a low half. A transaction has exactly 19 rising edges with select low throughout. After the last high half, select returns high and the clock stays low.
- R6: The outgoing data line changes only while the serial clock is low.
- R7: The input line is sampled as each rising edge is produced. Rising edges 5 to 12 collect the MSB-first byte, and edges 12 to 19 collect the LSB-first byte. If the two bytes are equal, the result takes the value; the result changes at no other time.
- R8: On disagreement, the result keeps its previous value and mismatch is set. Mismatch is held until the next accepted start, which clears it.
- R9: Done is high for exactly one system cycle, the cycle after select returns high. The result and mismatch are valid in that cycle.
- R10: A start request that arrives during a transaction is ignored. It does not change the timing or the configuration bits sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transaction request |
| mode_i | input | 2 | Input configuration code {single/diff, odd/sign} |
| cs_n_o | output | 1 | Converter select, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| di_o | output | 1 | Serial data to the converter |
| do_i | input | 1 | Serial data from the converter |
| result_o | output | 8 | Last committed conversion value |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| mismatch_o | output | 1 | The two received copies disagreed |

## Verification
The bench builds the block with HALF_DIV = 3. That value is odd, so the phase counter must wrap at a value that is not a power of two. It also keeps a transaction near 116 cycles, which makes room for matched, mismatched, overlapping and back-to-back transactions in one short run.

A behavioural converter on the bench drives the input line from the edges it sees on the serial clock. A counting model predicts select, clock, done, result and mismatch on every cycle. A mismatch is provoked by corrupting one bit of the LSB-first copy only.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LOW  = 2'd1,
        SQ_HIGH = 2'd2,
        SQ_FIN  = 2'd3
    } sq_state_e;

    // input configuration codes {single/diff, odd/sign}
    localparam logic [1:0] MODE_SE_CH0   = 2'b10;
    localparam logic [1:0] MODE_SE_CH1   = 2'b11;
    localparam logic [1:0] MODE_DIFF_P0  = 2'b00;
    localparam logic [1:0] MODE_DIFF_P1  = 2'b01;

endpackage

// File: rtl/sadc_tick.sv
module sadc_tick #(
    parameter int HALF_DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = run_i && (cnt_q == LAST);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R5

    AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
    import sadc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] mode_i,
    input  logic              tick_i,
    input  logic              do_i,
    output logic              run_o,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              di_o,
    output logic              acc_o,
    output logic              fin_o,
    output logic [DATA_W-1:0] msb_o,
    output logic [DATA_W-1:0] lsb_o
);
    // rising-edge positions, counted from 0 (start bit)
    localparam int NULL_POS  = ADDR_W + 1;
    localparam int MSB_FIRST = NULL_POS + 1;
    localparam int MSB_LAST  = MSB_FIRST + DATA_W - 1;
    localparam int LSB_LAST  = MSB_LAST + DATA_W - 1;
    localparam int EW        = $clog2(LSB_LAST + 1);

    localparam logic [EW-1:0] P_MSB_FIRST = EW'(MSB_FIRST);
    localparam logic [EW-1:0] P_MSB_LAST  = EW'(MSB_LAST);
    localparam logic [EW-1:0] P_LSB_LAST  = EW'(LSB_LAST);
    localparam logic [EW-1:0] P_ADDR_END  = EW'(ADDR_W);

    typedef struct packed {
        sq_state_e         st;
        logic [EW-1:0]     pos;
        logic              cs_n;
        logic              sclk;
        logic              di;
        logic [ADDR_W-1:0] mode;
        logic [DATA_W-1:0] msb;
        logic [DATA_W-1:0] lsb;
    } seq_s;

    seq_s q, n;
    logic acc;
    logic [EW-1:0] nxt_pos;

    always_comb begin
        n       = q;
        acc     = 1'b0;
        nxt_pos = q.pos + 1'b1;
        case (q.st)
            SQ_IDLE: begin
                n.cs_n = 1'b1;
                n.sclk = 1'b0;
                if (start_i) begin
                    acc    = 1'b1;
                    n.st   = SQ_LOW;
                    n.pos  = '0;
                    n.cs_n = 1'b0;
                    n.di   = 1'b1;
                    n.mode = mode_i;
                end
            end
            SQ_LOW: begin
                if (tick_i) begin
                    n.sclk = 1'b1;
                    n.st   = SQ_HIGH;
                    if (q.pos >= P_MSB_FIRST && q.pos <= P_MSB_LAST) begin
                        n.msb = {q.msb[DATA_W-2:0], do_i};
                    end
                    if (q.pos >= P_MSB_LAST && q.pos <= P_LSB_LAST) begin
                        n.lsb = {do_i, q.lsb[DATA_W-1:1]};
                    end
                end
            end
            SQ_HIGH: begin
                if (tick_i) begin
                    n.sclk = 1'b0;
                    if (q.pos == P_LSB_LAST) begin
                        n.st   = SQ_FIN;
                        n.cs_n = 1'b1;
                        n.di   = 1'b1;
                    end else begin
                        n.st  = SQ_LOW;
                        n.pos = nxt_pos;
                        n.di  = 1'b1;
                        for (int b = 0; b < ADDR_W; b++) begin
                            if (nxt_pos == EW'(b + 1)) begin
                                n.di = q.mode[ADDR_W-1-b];
                            end
                        end
                    end
                end
            end
            default: begin
                n.st   = SQ_IDLE;
                n.cs_n = 1'b1;
                n.sclk = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: SQ_IDLE, pos: '0, cs_n: 1'b1, sclk: 1'b0, di: 1'b1,
                   mode: '0, msb: '0, lsb: '0};
        end else begin
            q <= n;
        end
    end

    assign run_o  = (q.st == SQ_LOW) || (q.st == SQ_HIGH);
    assign fin_o  = (q.st == SQ_FIN);
    assign acc_o  = acc;
    assign cs_n_o = q.cs_n;
    assign sclk_o = q.sclk;
    assign di_o   = q.di;
    assign msb_o  = q.msb;
    assign lsb_o  = q.lsb;

    AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        q.cs_n |-> !q.sclk); // R5

    AST_DI_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.di) |-> !q.sclk); // R6

    AST_DI_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && q.pos > P_ADDR_END) |-> q.di); // R4

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != SQ_IDLE) |=> $stable(q.mode)); // R10

    AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_LOW) |=> !q.cs_n); // R5

endmodule

// File: rtl/sadc_judge.sv
module sadc_judge #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic              fin_i,
    input  logic [DATA_W-1:0] msb_i,
    input  logic [DATA_W-1:0] lsb_i,
    output logic [DATA_W-1:0] result_o,
    output logic              done_o,
    output logic              mism_o
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              done;
        logic              mis;
    } judge_s;

    judge_s q, n;

    always_comb begin
        n      = q;
        n.done = fin_i;
        if (acc_i) begin
            n.mis = 1'b0;
        end
        if (fin_i) begin
            if (msb_i == lsb_i) begin
                n.res = msb_i;
                n.mis = 1'b0;
            end else begin
                n.mis = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{res: '0, done: 1'b0, mis: 1'b0};
        end else begin
            q <= n;
        end
    end

    assign result_o = q.res;
    assign done_o   = q.done;
    assign mism_o   = q.mis;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done); // R9

    AST_RESULT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !q.done |-> $stable(q.res)); // R7

    AST_KEEP_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.mis) |-> $stable(q.res)); // R8

    AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mis && !acc_i && !fin_i) |=> q.mis); // R8

endmodule

// File: rtl/sadc_reader.sv
module sadc_reader #(
    parameter int HALF_DIV = 125,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              di_o,
    input  logic              do_i,
    output logic [DATA_W-1:0] result_o,
    output logic              done_o,
    output logic              mismatch_o
);
    localparam int ADDR_W = 2;

    logic              run, tick, acc, fin;
    logic [DATA_W-1:0] msb_w, lsb_w;

    sadc_tick #(.HALF_DIV(HALF_DIV)) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    sadc_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .mode_i  (mode_i),
        .tick_i  (tick),
        .do_i    (do_i),
        .run_o   (run),
        .cs_n_o  (cs_n_o),
        .sclk_o  (sclk_o),
        .di_o    (di_o),
        .acc_o   (acc),
        .fin_o   (fin),
        .msb_o   (msb_w),
        .lsb_o   (lsb_w)
    );

    sadc_judge #(.DATA_W(DATA_W)) i_judge (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_i    (acc),
        .fin_i    (fin),
        .msb_i    (msb_w),
        .lsb_i    (lsb_w),
        .result_o (result_o),
        .done_o   (done_o),
        .mism_o   (mismatch_o)
    );

    AST_DONE_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o && $past(cs_n_o))); // R9

endmodule

// File: tb/test_sadc_reader.sv
module test_sadc_reader;
    localparam int CLK_PERIOD = 10;
    localparam int HD         = 3;
    localparam int DW         = 8;
    localparam int EDGES      = 4 + 2 * DW - 1;
    localparam int FRAME      = 2 * EDGES * HD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    mode_i = 2'b00;
    logic          cs_n_o, sclk_o, di_o;
    logic          do_r = 1'b0;
    logic [DW-1:0] result_o;
    logic          done_o, mismatch_o;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sadc_reader #(.HALF_DIV(HD), .DATA_W(DW)) i_sadc_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .cs_n_o     (cs_n_o),
        .sclk_o     (sclk_o),
        .di_o       (di_o),
        .do_i       (do_r),
        .result_o   (result_o),
        .done_o     (done_o),
        .mismatch_o (mismatch_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // values the behavioural converter returns
    logic [DW-1:0] v_msb = '0;
    logic [DW-1:0] v_lsb = '0;

    // reference model: cycle counter since accepted start
    bit            rbusy = 1'b0;
    int            rc = 0;
    logic [DW-1:0] e_res = '0;
    bit            e_mis = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            rbusy = 1'b0; rc = 0; e_res = '0; e_mis = 1'b0;
        end else begin
            if (rbusy) begin
                if (rc == FRAME + 1) rbusy = 1'b0;
                else rc = rc + 1;
            end
            if (rbusy && rc == FRAME + 1) begin
                if (v_msb == v_lsb) begin e_res = v_msb; e_mis = 1'b0; end
                else e_mis = 1'b1;
            end
            if (!rbusy && start_i) begin  // R10: ignored while busy
                rbusy = 1'b1; rc = 0; e_mis = 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            bit e_cs, e_sclk, e_done;
            e_cs   = !(rbusy && rc < FRAME);
            e_sclk = rbusy && rc < FRAME && ((rc / HD) % 2 == 1);
            e_done = rbusy && rc == FRAME + 1;
            chk(cs_n_o == e_cs, "R5 R10 select", cs_n_o, e_cs);
            chk(sclk_o == e_sclk, "R5 sclk", sclk_o, e_sclk);
            chk(done_o == e_done, "R9 done", done_o, e_done);
            chk(result_o == e_res, "R7 result", result_o, e_res);
            chk(mismatch_o == e_mis, "R8 mismatch", mismatch_o, e_mis);
        end
    end

    // behavioural converter
    logic      psclk = 1'b0;
    logic      pdi = 1'b1;
    int        idx = 0;
    int        last_cnt = 0;
    logic [31:0] dibits = '0;
    bit        di_bad = 1'b0;

    always @(negedge clk) begin
        if (cs_n_o) begin
            if (idx != 0) last_cnt = idx;
            idx = 0;
            do_r = 1'b0;
            psclk = 1'b0;
        end else begin
            if (sclk_o && !psclk) begin
                idx++;
                if (idx < 32) dibits[idx] = di_o;
            end
            if (!sclk_o && psclk) begin
                if (idx >= 4 && idx <= 11) do_r = v_msb[11 - idx];
                else if (idx >= 12 && idx <= 18) do_r = v_lsb[idx - 11];
                else do_r = 1'b0;
            end
            if (sclk_o && psclk && di_o !== pdi) di_bad = 1'b1;
            psclk = sclk_o;
        end
        pdi = di_o;
    end

    task automatic run_txn(input logic [1:0] md, input logic [DW-1:0] vm,
                           input logic [DW-1:0] vl, input bit stray);
        v_msb = vm; v_lsb = vl; di_bad = 1'b0; dibits = '0;
        mode_i = md;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        mode_i = ~md;
        if (stray) begin
            // R10: second request mid-transaction
            repeat (HD * 10) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (FRAME + 3 - HD * 10 - 1) @(negedge clk);
        end else begin
            repeat (FRAME + 3) @(negedge clk);
        end
        chk(last_cnt == EDGES, "R5 rising edge count", last_cnt, EDGES);
        chk(dibits[1] == 1'b1, "R2 start bit", dibits[1], 1);
        chk(dibits[2] == md[1], "R3 single/diff bit", dibits[2], md[1]);
        chk(dibits[3] == md[0], "R3 odd/sign bit", dibits[3], md[0]);
        chk(dibits[EDGES:4] == '1, "R4 DI released", dibits[EDGES:4], 32'hFFFF);
        chk(!di_bad, "R6 DI stable while sclk high", di_bad, 0);
        chk(result_o == e_res, "R7 R8 result after transaction", result_o, e_res);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n_o == 1'b1, "R1 select idle", cs_n_o, 1);
        chk(sclk_o == 1'b0, "R1 sclk idle", sclk_o, 0);
        chk(done_o == 1'b0, "R1 done idle", done_o, 0);
        chk(result_o == '0, "R1 result reset", result_o, 0);
        chk(mismatch_o == 1'b0, "R1 mismatch reset", mismatch_o, 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        repeat (2) @(negedge clk);

        run_txn(2'b10, 8'hA5, 8'hA5, 1'b0);   // R3 channel 0 single-ended
        run_txn(2'b11, 8'h3C, 8'h3C, 1'b1);   // R3 channel 1, R10 stray start
        run_txn(2'b00, 8'h00, 8'h00, 1'b0);
        run_txn(2'b01, 8'hFF, 8'hFF, 1'b0);
        run_txn(2'b10, 8'h5A, 8'hDA, 1'b0);   // R8 mismatch keeps 0xFF
        chk(mismatch_o == 1'b1, "R8 mismatch held", mismatch_o, 1);
        chk(result_o == 8'hFF, "R8 previous result kept", result_o, 8'hFF);
        run_txn(2'b11, 8'h81, 8'h81, 1'b0);   // R8 cleared, R7 commit
        chk(mismatch_o == 1'b0, "R8 mismatch cleared", mismatch_o, 0);

        // back-to-back: start held high across the idle cycle
        v_msb = 8'h69; v_lsb = 8'h69; mode_i = 2'b01;
        start_i = 1'b1;
        repeat (FRAME + 3) @(negedge clk);
        start_i = 1'b0;
        repeat (FRAME + 3) @(negedge clk);
        chk(result_o == 8'h69, "R7 back-to-back result", result_o, 8'h69);
        chk(dibits[3] == 1'b1, "R3 back-to-back odd bit", dibits[3], 1);

        cmp_en = 1'b0;
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule